// File: doc/BRIEF.md
# Unsigned Non-Restoring Array Divider

This block divides an unsigned dividend by an unsigned divisor of the same width (8 bits by default) and returns a quotient and a remainder of that width. It is the divide unit of a small microcontroller ALU. A one-cycle `start` pulse presents the operands. One clock later the registered result appears, and `done` is high for exactly that cycle.

The main path is a chain of add/subtract rows. Each row uses the sign of the previous partial remainder to decide whether it adds or subtracts the divisor, so no row needs a restore multiplexer. The chain produces the quotient one bit per row, from the most significant bit down. A final correction row adds the divisor back, and a multiplexer keeps that corrected remainder only when the last partial remainder is negative.

Because the chain works on signed partial remainders one bit wider than the operands, it cannot handle a divisor whose top bit is set. Such divisors go to a separate path that performs one trial subtraction and restores the dividend if the difference is negative. An output selector chooses between the two paths. A zero divisor raises the overflow flag and returns a fixed, deterministic result. The carry flag is always returned cleared.

Top module: `nrd_divider`

## Requirements
- R1: After reset, `done`, `quotient`, `remainder` and `ovf_flag` are all 0. A `start` sampled high at a rising edge makes `done` high in the following cycle with the result valid. `done` is low in every cycle that does not follow a sampled `start`.
- R2: For every non-zero divisor, the registered result satisfies quotient × divisor + remainder = dividend, and remainder < divisor.
- R3: When the divisor's most significant bit is 1, the quotient is 1 and the remainder is dividend − divisor if dividend ≥ divisor. Otherwise the quotient is 0 and the remainder equals the dividend.
- R4: When the divisor is zero, `ovf_flag` is 1, the quotient is all ones (0xFF at the default width) and the remainder equals the dividend.
- R5: For a non-zero divisor, `ovf_flag` is 0.
- R6: `carry_flag` is 0 after reset and after every divide.
- R7: While no `start` is sampled, `quotient`, `remainder` and `ovf_flag` keep the values of the last result.
- R8: Starts on consecutive cycles each produce their own result on consecutive cycles, in issue order.
- R9: A divisor of 1 returns the dividend as the quotient and a remainder of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Operands are valid; begin a divide |
| dividend | input | W (8) | Unsigned dividend |
| divisor | input | W (8) | Unsigned divisor |
| done | output | 1 | Result valid, one cycle per start |
| quotient | output | W (8) | Unsigned quotient |
| remainder | output | W (8) | Unsigned remainder |
| ovf_flag | output | 1 | Set on division by zero |
| carry_flag | output | 1 | Always cleared |

## Verification
On every cycle, the assertions check the division identity and the remainder bound against the operands sampled one cycle earlier. They also check that a large divisor yields a quotient of 0 or 1, that a zero divisor gives the fixed result, that `done` follows `start` by exactly one cycle, and that the outputs hold between results. The bench's scenarios are needed to show the rest. They sweep every dividend and divisor pair back to back, so that results stay in issue order under continuous issue. They also cover the reset values, the cleared carry, the boundary divisors 0, 1, 0x80 and 0xFF, and the hold of the outputs across idle gaps.

// File: rtl/nrd_pkg.sv
package nrd_pkg;

    localparam int NRD_W = 8;

    typedef enum logic {
        ROW_SUB = 1'b0,
        ROW_ADD = 1'b1
    } row_op_e;

    // A negative partial remainder makes the next row add back instead of restoring.
    function automatic row_op_e row_op(input logic part_sign);
        return part_sign ? ROW_ADD : ROW_SUB;
    endfunction

endpackage

// File: rtl/nrd_row.sv
module nrd_row
    import nrd_pkg::*;
#(
    parameter int W = NRD_W
) (
    input  logic [W:0]   part_i,
    input  logic         dvd_bit_i,
    input  logic [W-1:0] dsr_i,
    output logic [W:0]   part_o,
    output logic         q_o
);
    logic [W:0] shifted;
    logic [W:0] operand;
    row_op_e    op;

    always_comb begin
        op      = row_op(part_i[W]);
        // |part| < 2^(W-1), so dropping the top bit keeps the sign intact
        shifted = {part_i[W-1:0], dvd_bit_i};
        operand = {1'b0, dsr_i};
        part_o  = (op == ROW_SUB) ? (shifted - operand) : (shifted + operand);
        q_o     = ~part_o[W];
    end
endmodule

// File: rtl/nrd_array.sv
module nrd_array
    import nrd_pkg::*;
#(
    parameter int W = NRD_W
) (
    input  logic [W-1:0] dvd_i,
    input  logic [W-1:0] dsr_i,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o
);
    localparam int ROWS = W;

    logic [W:0]   part [ROWS+1];
    logic [W-1:0] fixed_rem;

    assign part[0] = '0;

    generate
        for (genvar i = 0; i < ROWS; i++) begin : g_row
            nrd_row #(.W(W)) row_i (
                .part_i    (part[i]),
                .dvd_bit_i (dvd_i[W-1-i]),
                .dsr_i     (dsr_i),
                .part_o    (part[i+1]),
                .q_o       (quo_o[W-1-i])
            );
        end
    endgenerate

    // Correction row: add the divisor back; result lies in [0, divisor)
    always_comb begin
        fixed_rem = part[ROWS][W-1:0] + dsr_i;
        rem_o     = part[ROWS][W] ? fixed_rem : part[ROWS][W-1:0];
    end
endmodule

// File: rtl/nrd_side.sv
module nrd_side
    import nrd_pkg::*;
#(
    parameter int W = NRD_W
) (
    input  logic [W-1:0] dvd_i,
    input  logic [W-1:0] dsr_i,
    output logic         q_o,
    output logic [W-1:0] rem_o
);
    logic [W:0] trial;

    always_comb begin
        trial = {1'b0, dvd_i} - {1'b0, dsr_i};
        q_o   = ~trial[W];
        rem_o = trial[W] ? dvd_i : trial[W-1:0];
    end
endmodule

// File: rtl/nrd_divider.sv
module nrd_divider
    import nrd_pkg::*;
#(
    parameter int W = NRD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         ovf_flag,
    output logic         carry_flag
);
    localparam int W2 = 2 * W;

    typedef struct packed {
        logic         ovf;
        logic [W-1:0] quo;
        logic [W-1:0] rem;
    } div_res_t;

    logic [W-1:0] arr_quo, arr_rem, side_rem;
    logic         side_q;
    logic         zero_dsr, big_dsr;
    div_res_t     next_res, res_q;
    logic         done_q;

    nrd_array #(.W(W)) array_i (
        .dvd_i (dividend),
        .dsr_i (divisor),
        .quo_o (arr_quo),
        .rem_o (arr_rem)
    );

    nrd_side #(.W(W)) side_i (
        .dvd_i (dividend),
        .dsr_i (divisor),
        .q_o   (side_q),
        .rem_o (side_rem)
    );

    always_comb begin
        zero_dsr = (divisor == '0);
        big_dsr  = divisor[W-1];
        if (zero_dsr) begin
            next_res = '{ovf: 1'b1, quo: '1, rem: dividend};
        end else if (big_dsr) begin
            next_res = '{ovf: 1'b0, quo: {{(W-1){1'b0}}, side_q}, rem: side_rem};
        end else begin
            next_res = '{ovf: 1'b0, quo: arr_quo, rem: arr_rem};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            res_q  <= '0;
        end else begin
            done_q <= start;
            if (start) begin
                res_q <= next_res;
            end
        end
    end

    assign done       = done_q;
    assign quotient   = res_q.quo;
    assign remainder  = res_q.rem;
    assign ovf_flag   = res_q.ovf;
    assign carry_flag = 1'b0;

    AST_EXACT_IDENTITY: assert property (@(posedge clk) disable iff (rst)
        (start && divisor != '0) |=>
        (({{W{1'b0}}, quotient} * {{W{1'b0}}, $past(divisor)}) + {{W{1'b0}}, remainder})
            == W2'({{W{1'b0}}, $past(dividend)})); // R2

    AST_REM_BOUND: assert property (@(posedge clk) disable iff (rst)
        (start && divisor != '0) |=> (remainder < $past(divisor))); // R2

    AST_BIG_DSR_QUO: assert property (@(posedge clk) disable iff (rst)
        (start && divisor[W-1]) |=> (quotient <= W'(1) && !ovf_flag)); // R3

    AST_ZERO_DSR: assert property (@(posedge clk) disable iff (rst)
        (start && divisor == '0) |=>
        (ovf_flag && quotient == '1 && remainder == $past(dividend))); // R4

    AST_NO_OVF: assert property (@(posedge clk) disable iff (rst)
        (start && divisor != '0) |=> !ovf_flag); // R5

    AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        start |=> done); // R1

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done); // R1

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(quotient) && $stable(remainder) && $stable(ovf_flag))); // R7
endmodule

// File: tb/nrd_divider_tb_top.sv
`timescale 1ns/1ps
module nrd_divider_tb_top;
    localparam int W = 8;

    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] d;
        logic [W-1:0] q;
        logic [W-1:0] r;
        logic         ovf;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         done;
    logic [W-1:0] quotient, remainder;
    logic         ovf_flag, carry_flag;

    int errors = 0;
    int checks = 0;
    exp_t sb_q[$];
    logic         have_last = 1'b0;
    logic [W-1:0] last_q, last_r;
    logic         last_ovf;
    logic         finished = 1'b0;

    always #2 clk = ~clk;

    nrd_divider #(.W(W)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .dividend   (dividend),
        .divisor    (divisor),
        .done       (done),
        .quotient   (quotient),
        .remainder  (remainder),
        .ovf_flag   (ovf_flag),
        .carry_flag (carry_flag)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic string req_of(input logic [W-1:0] d);
        if (d == '0) return "R4";
        if (d[W-1]) return "R3";
        if (d == 1) return "R9";
        return "R2";
    endfunction

    // Driver: issue one divide and push its expected result
    task automatic issue(input logic [W-1:0] a, input logic [W-1:0] d);
        exp_t e;
        @(negedge clk);
        start    = 1'b1;
        dividend = a;
        divisor  = d;
        e.a = a;
        e.d = d;
        if (d == '0) begin
            e.q = '1; e.r = a; e.ovf = 1'b1;
        end else begin
            e.q = a / d; e.r = a % d; e.ovf = 1'b0;
        end
        sb_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            start = 1'b0;
        end
    endtask

    // Monitor: compare each result as it appears
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (done) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R1", "done without start", 1, 0);
                end else begin
                    exp_t e;
                    string rq;
                    e  = sb_q.pop_front();
                    rq = req_of(e.d);
                    check(quotient == e.q, rq, $sformatf("quotient %0d/%0d", e.a, e.d), quotient, e.q);
                    check(remainder == e.r, rq, $sformatf("remainder %0d/%0d", e.a, e.d), remainder, e.r);
                    check(ovf_flag == e.ovf, e.ovf ? "R4" : "R5", "ovf_flag", ovf_flag, e.ovf);
                    check(carry_flag == 1'b0, "R6", "carry_flag", carry_flag, 0);
                    last_q    = quotient;
                    last_r    = remainder;
                    last_ovf  = ovf_flag;
                    have_last = 1'b1;
                end
            end else if (have_last) begin
                check(quotient == last_q && remainder == last_r && ovf_flag == last_ovf,
                      "R7", "hold while idle", {quotient, remainder}, {last_q, last_r});
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 / R6: reset state
        check(done == 0 && quotient == 0 && remainder == 0 && ovf_flag == 0, "R1",
              "reset state", {done, quotient, remainder, ovf_flag}, 0);
        check(carry_flag == 0, "R6", "carry after reset", carry_flag, 0);
        @(negedge clk);
        rst = 1'b0;
        idle(2);

        // Directed corners with idle gaps: R2, R3, R4, R9, R7
        issue(8'd200, 8'd7);   idle(3);
        issue(8'd255, 8'd1);   idle(2);   // R9
        issue(8'd0,   8'd1);   idle(2);   // R9
        issue(8'd77,  8'd0);   idle(3);   // R4
        issue(8'd200, 8'd128); idle(2);   // R3: q=1
        issue(8'd127, 8'd128); idle(2);   // R3: q=0
        issue(8'd255, 8'd255); idle(2);   // R3: q=1 r=0
        issue(8'd254, 8'd255); idle(2);   // R3: q=0
        issue(8'd255, 8'd127); idle(2);   // R2 largest main-path divisor
        issue(8'd5,   8'd9);   idle(4);   // R2 dividend below divisor

        // R8: exhaustive sweep, one start per cycle
        for (int a = 0; a < 256; a++) begin
            for (int d = 0; d < 256; d++) begin
                issue(W'(a), W'(d));
            end
        end
        idle(5);
        check(sb_q.size() == 0, "R8", "all results returned", sb_q.size(), 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule